// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block is the event side of a system power-management unit. It claims a 64-byte I/O window whose base and enable are supplied by configuration-space registers held elsewhere, and within that window it exposes a 16-bit event status register, a 16-bit event enable register and a free-running power-management timer. Event sources (RTC alarm, power button, global lock release, timer overflow and a wake event) set latched status bits. Software clears them by writing ones. A level-sensitive system control interrupt (SCI) is raised while any of four sources is both pending and enabled.

The host side is a simple single-cycle I/O port: an address, read and write strobes and a 32-bit data path. The block answers with a combinational claim signal and read data in the same cycle. Writes take effect at the clock edge that ends the access cycle.

Top module: `pm_acpi_evt`

## Requirements
- R1: The window base is `cfg_base[15:0] & 16'hFFC0`. An access is claimed (`io_claim` high during `io_rd` or `io_wr`) exactly when `io_addr[15:6]` equals the base bits [15:6] and the window is enabled. Bits [31:16] and [5:0] of `cfg_base` are ignored.
- R2: When `cfg_ctl[0]` is 0 no access is claimed, read data is zero, and writes change no register.
- R3: The status register is read at window offset 0x00 in `io_rdata[15:0]`. Bit 0 is timer overflow, bit 5 is global lock, bit 8 is power button, bit 10 is RTC alarm and bit 15 is wake. All other bits read as 0. A one-cycle pulse on `ev_glock`, `ev_pwrbtn`, `ev_rtc` or `ev_wake` sets its bit.
- R4: A write to offset 0x00 clears every status bit whose `io_wdata` bit is 1. Bits written with 0 keep their value.
- R5: The enable register is a 16-bit read/write register at offset 0x02, using `io_wdata[15:0]` and `io_rdata[15:0]`.
- R6: The timer is a TMR_W-bit counter (24 by default) that increments on every clock and wraps. It is read zero-extended at offset 0x08.
- R7: Status bit 0 is set in the cycle in which the timer's most significant bit changes value, in either direction.
- R8: `sci` is high exactly when status AND enable is nonzero in bit 0, 5, 8 or 10, with no added latency. The wake bit never raises `sci`.
- R9: When a set event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `tmr_armed` is high exactly while enable bit 0 is 1 and status bit 0 is 0.
- R11: After a synchronous reset the status register, the enable register and the timer are zero, and `sci` and `tmr_armed` are low.
- R12: Reads at any other offset inside the window are claimed and return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 32 | Configuration dword holding the window base |
| cfg_ctl | input | 8 | Configuration control byte; bit 0 enables the window |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, zero when not a claimed read |
| io_claim | output | 1 | Access falls in the enabled window |
| ev_rtc | input | 1 | RTC alarm event pulse |
| ev_pwrbtn | input | 1 | Power button event pulse |
| ev_glock | input | 1 | Global lock event pulse |
| ev_wake | input | 1 | Wake event pulse (not an SCI source) |
| sci | output | 1 | Level system control interrupt |
| tmr_armed | output | 1 | Timer overflow can still raise a new event |

## Verification
Two functions can act in the same cycle. The timer's MSB can flip while software writes a one to clear status bit 0, and an external event pulse can arrive while its bit is being cleared. The bench follows the reference model's copy of the timer and issues the clear write at the exact negative edge before the flip. It also drives a power-button pulse together with a clear of bit 8. In both cases a later read must show the bit still set, and `sci` must follow the enable. All outputs are also compared against the behavioural model on every clock, so any loss of the event in that cycle is detected.

// File: rtl/pm_acpi_pkg.sv
// Package: shared constants for the power-management event block.
// Assumes a 16-bit I/O address space and a 64-byte window.
package pm_acpi_pkg;
    localparam int STS_W   = 16;
    localparam int B_TMR   = 0;
    localparam int B_GLOCK = 5;
    localparam int B_PWR   = 8;
    localparam int B_RTC   = 10;
    localparam int B_WAKE  = 15;

    localparam logic [STS_W-1:0] SCI_SRC  = (16'd1 << B_TMR) | (16'd1 << B_GLOCK)
                                          | (16'd1 << B_PWR) | (16'd1 << B_RTC);
    localparam logic [STS_W-1:0] STS_IMPL = SCI_SRC | (16'd1 << B_WAKE);

    localparam logic [5:0] OFF_STS = 6'h00;
    localparam logic [5:0] OFF_EN  = 6'h02;
    localparam logic [5:0] OFF_TMR = 6'h08;

    typedef enum logic [1:0] {SEL_NONE, SEL_STS, SEL_EN, SEL_TMR} reg_sel_e;
endpackage

// File: rtl/pm_win_decode.sv
// Window decoder: matches the I/O address against a base masked to the
// window size and picks the register selected by the offset.
// Assumes WIN_LOG is 6 so that the register offsets fit the window.
module pm_win_decode
    import pm_acpi_pkg::*;
#(
    parameter int AW      = 16,
    parameter int WIN_LOG = 6
) (
    input  logic [AW-1:0] io_addr,
    input  logic [31:0]   cfg_base,
    input  logic          win_en,
    output logic          in_win,
    output reg_sel_e      sel
);
    localparam int TAG_W = AW - WIN_LOG;

    logic [WIN_LOG-1:0] off;

    // Window hit from the upper address bits against the aligned base.
    always_comb begin
        in_win = win_en && (io_addr[AW-1:WIN_LOG] == cfg_base[AW-1:WIN_LOG]);
    end

    // Offset to register selection.
    always_comb begin
        off = io_addr[WIN_LOG-1:0];
        if (off == OFF_STS[WIN_LOG-1:0])      sel = SEL_STS;
        else if (off == OFF_EN[WIN_LOG-1:0])  sel = SEL_EN;
        else if (off == OFF_TMR[WIN_LOG-1:0]) sel = SEL_TMR;
        else                                  sel = SEL_NONE;
    end

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = '0;
endmodule

// File: rtl/pm_timer.sv
// Free-running power-management timer; flags the cycle in which its MSB
// will change at the coming edge. Assumes TMR_W >= 2.
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TMR_W-1:0] cnt,
    output logic             msb_flip
);
    // Count every clock, wrap at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Low bits all ones: the next increment carries into the MSB.
    always_comb begin
        msb_flip = &cnt[TMR_W-2:0];
    end

    p_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt - $past(cnt)) == TMR_W'(1));
endmodule

// File: rtl/pm_evt_regs.sv
// Event status (write-one-to-clear, set wins) and enable registers with
// SCI and timer-arm generation. Assumes single-cycle event pulses.
module pm_evt_regs
    import pm_acpi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wdata,
    input  logic             tmr_flip,
    input  logic             ev_rtc,
    input  logic             ev_pwrbtn,
    input  logic             ev_glock,
    input  logic             ev_wake,
    output logic [STS_W-1:0] sts_q,
    output logic [STS_W-1:0] en_q,
    output logic             sci,
    output logic             tmr_armed
);
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;

    // Gather event pulses into their status positions.
    always_comb begin
        set_vec          = '0;
        set_vec[B_TMR]   = tmr_flip;
        set_vec[B_GLOCK] = ev_glock;
        set_vec[B_PWR]   = ev_pwrbtn;
        set_vec[B_RTC]   = ev_rtc;
        set_vec[B_WAKE]  = ev_wake;
        clr_vec          = wr_sts ? wdata : '0;
    end

    // Status update: clear first, then set, so a same-cycle event survives.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;
    end

    // Enable register load.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata;
    end

    // Interrupt level and timer arm state from registered values.
    always_comb begin
        sci       = |(sts_q & en_q & SCI_SRC);
        tmr_armed = en_q[B_TMR] & ~sts_q[B_TMR];
    end

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[B_RTC] && !ev_rtc) |=> !sts_q[B_RTC]);
    p_setwins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwrbtn |=> sts_q[B_PWR]);
    p_sci_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci) |-> $past((|set_vec) || wr_en));
endmodule

// File: rtl/pm_acpi_evt.sv
// Top: power-management event block in a relocatable 64-byte I/O window.
// Assumes single-cycle I/O accesses and TMR_W <= 32.
module pm_acpi_evt
    import pm_acpi_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_base,
    input  logic [7:0]  cfg_ctl,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_claim,
    input  logic        ev_rtc,
    input  logic        ev_pwrbtn,
    input  logic        ev_glock,
    input  logic        ev_wake,
    output logic        sci,
    output logic        tmr_armed
);
    localparam int AW      = 16;
    localparam int WIN_LOG = 6;

    logic             in_win;
    reg_sel_e         sel;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_flip;
    logic [STS_W-1:0] sts_w;
    logic [STS_W-1:0] en_w;
    logic             wr_sts;
    logic             wr_en;

    pm_win_decode #(.AW(AW), .WIN_LOG(WIN_LOG)) u_dec (
        .io_addr (io_addr),
        .cfg_base(cfg_base),
        .win_en  (cfg_ctl[0]),
        .in_win  (in_win),
        .sel     (sel)
    );

    pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (tmr_cnt),
        .msb_flip(tmr_flip)
    );

    // Write strobes for the two writable registers.
    always_comb begin
        wr_sts = io_wr && in_win && (sel == SEL_STS);
        wr_en  = io_wr && in_win && (sel == SEL_EN);
    end

    pm_evt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sts   (wr_sts),
        .wr_en    (wr_en),
        .wdata    (io_wdata[STS_W-1:0]),
        .tmr_flip (tmr_flip),
        .ev_rtc   (ev_rtc),
        .ev_pwrbtn(ev_pwrbtn),
        .ev_glock (ev_glock),
        .ev_wake  (ev_wake),
        .sts_q    (sts_w),
        .en_q     (en_w),
        .sci      (sci),
        .tmr_armed(tmr_armed)
    );

    // Claim and read-data multiplexer.
    always_comb begin
        io_claim = (io_rd || io_wr) && in_win;
        io_rdata = '0;
        if (io_rd && in_win) begin
            case (sel)
                SEL_STS: io_rdata[STS_W-1:0] = sts_w;
                SEL_EN:  io_rdata[STS_W-1:0] = en_w;
                SEL_TMR: io_rdata[TMR_W-1:0] = tmr_cnt;
                default: io_rdata = '0;
            endcase
        end
    end

    p_win_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cfg_ctl[0]) |=> $stable(en_w));
endmodule

// File: tb/pm_acpi_evt_test.sv
`timescale 1ns/100ps
module pm_acpi_evt_test;
    localparam int TW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [7:0]  cfg_ctl = '0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_claim;
    logic        ev_rtc = 1'b0, ev_pwrbtn = 1'b0, ev_glock = 1'b0, ev_wake = 1'b0;
    logic        sci, tmr_armed;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0]   m_sts = '0, m_en = '0;
    logic [TW-1:0] m_tmr = '0;

    pm_acpi_evt #(.TMR_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ctl(cfg_ctl),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_claim(io_claim),
        .ev_rtc(ev_rtc), .ev_pwrbtn(ev_pwrbtn), .ev_glock(ev_glock), .ev_wake(ev_wake),
        .sci(sci), .tmr_armed(tmr_armed)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_hit();
        return cfg_ctl[0] && ((io_addr & 16'hFFC0) == (cfg_base[15:0] & 16'hFFC0));
    endfunction

    function automatic logic [31:0] m_rdata();
        if (!(io_rd && m_hit())) return 32'h0;
        case (io_addr[5:0])
            6'h00:   return {16'h0, m_sts};
            6'h02:   return {16'h0, m_en};
            6'h08:   return 32'(m_tmr);
            default: return 32'h0;
        endcase
    endfunction

    // Reference model: update on the edge, compare 1 ns later.
    always @(posedge clk) begin
        logic [TW-1:0] nx;
        if (!rst_n) begin
            m_sts = '0; m_en = '0; m_tmr = '0;
        end else begin
            nx = m_tmr + 1'b1;
            if (io_wr && m_hit() && io_addr[5:0] == 6'h00) m_sts = m_sts & ~io_wdata[15:0];
            if (io_wr && m_hit() && io_addr[5:0] == 6'h02) m_en = io_wdata[15:0];
            if (nx[TW-1] != m_tmr[TW-1]) m_sts[0] = 1'b1;
            if (ev_glock)  m_sts[5]  = 1'b1;
            if (ev_pwrbtn) m_sts[8]  = 1'b1;
            if (ev_rtc)    m_sts[10] = 1'b1;
            if (ev_wake)   m_sts[15] = 1'b1;
            m_tmr = nx;
        end
        #1;
        chk("R8 sci", {31'b0, sci}, {31'b0, |(m_sts & m_en & 16'h0521)});
        chk("R10 armed", {31'b0, tmr_armed}, {31'b0, m_en[0] & ~m_sts[0]});
        chk("R1 claim", {31'b0, io_claim}, {31'b0, (io_rd || io_wr) && m_hit()});
        chk("R12 rdata", io_rdata, m_rdata());
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] mask,
                      input logic [31:0] exp, input string req);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #1 chk(req, io_rdata & mask, exp);
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_rtc = 1'b1;
            1: ev_pwrbtn = 1'b1;
            2: ev_glock = 1'b1;
            default: ev_wake = 1'b1;
        endcase
        @(negedge clk); ev_rtc = 0; ev_pwrbtn = 0; ev_glock = 0; ev_wake = 0;
    endtask

    initial begin
        logic [31:0] t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cfg_base = 32'h1234_5A7F;
        // R11: reset state, read before any event can set bits (window off -> via enable)
        cfg_ctl = 8'h01;
        rd(16'h5A40, 32'hFFFF, 32'h0, "R11 status after reset");
        rd(16'h5A42, 32'hFFFF, 32'h0, "R11 enable after reset");
        chk("R11 sci low", {31'b0, sci}, 32'h0);
        // R1: base masking and window edges
        rd(16'h5A7F, 32'hFFFF_FFFF, 32'h0, "R1 top of window reads 0");
        @(negedge clk); io_addr = 16'h5A80; io_rd = 1'b1;
        #1 chk("R1 above window not claimed", {31'b0, io_claim}, 32'h0);
        io_addr = 16'h5A3F;
        #1 chk("R1 below window not claimed", {31'b0, io_claim}, 32'h0);
        io_addr = 16'h5A44;
        #1 chk("R1 inside window claimed", {31'b0, io_claim}, 32'h1);
        @(negedge clk); io_rd = 1'b0;
        // R5: enable register
        wr(16'h5A42, 32'hFFFF_A5C3);
        rd(16'h5A42, 32'hFFFF_FFFF, 32'h0000_A5C3, "R5 enable readback");
        wr(16'h5A42, 32'h0000_0520);
        // R3 / R8: events and SCI
        pulse(1);
        rd(16'h5A40, 32'h0000_0100, 32'h0000_0100, "R3 power button bit 8");
        chk("R8 sci from power button", {31'b0, sci}, 32'h1);
        pulse(3);
        rd(16'h5A40, 32'h0000_8000, 32'h0000_8000, "R3 wake bit 15");
        // R4: write-one-to-clear and zero no effect
        wr(16'h5A40, 32'h0000_0000);
        rd(16'h5A40, 32'h0000_8100, 32'h0000_8100, "R4 zero write keeps bits");
        wr(16'h5A40, 32'h0000_0100);
        rd(16'h5A40, 32'h0000_8100, 32'h0000_8000, "R4 clear bit 8 only");
        chk("R8 wake never raises sci", {31'b0, sci}, 32'h0);
        pulse(0);
        chk("R8 sci from rtc", {31'b0, sci}, 32'h1);
        pulse(2);
        wr(16'h5A40, 32'h0000_0400);
        chk("R8 sci held by global lock", {31'b0, sci}, 32'h1);
        wr(16'h5A40, 32'h0000_FFFF);
        // R12: other offset writes ignored
        wr(16'h5A44, 32'h0000_FFFF);
        rd(16'h5A42, 32'hFFFF, 32'h0000_0520, "R12 write to unused offset ignored");
        rd(16'h5A46, 32'hFFFF_FFFF, 32'h0, "R12 unused offset reads 0");
        // R2: disabled window
        cfg_ctl = 8'hFE;
        wr(16'h5A42, 32'h0000_0001);
        rd(16'h5A42, 32'hFFFF_FFFF, 32'h0, "R2 disabled read is zero");
        cfg_ctl = 8'h01;
        rd(16'h5A42, 32'hFFFF, 32'h0000_0520, "R2 disabled write ignored");
        // R6: timer increments by one per clock
        @(negedge clk); io_addr = 16'h5A48; io_rd = 1'b1;
        #1 t0 = io_rdata;
        @(negedge clk); #1 chk("R6 timer step", (io_rdata - t0) & 32'hFF, 32'h1);
        chk("R6 timer zero-extended", io_rdata & 32'hFFFF_FF00, 32'h0);
        @(negedge clk); io_rd = 1'b0;
        // R7 / R10: MSB flip sets bit 0
        wr(16'h5A42, 32'h0000_0001);
        wr(16'h5A40, 32'h0000_0001);
        chk("R10 armed when enabled and clear", {31'b0, tmr_armed}, {31'b0, ~m_sts[0]});
        repeat (1 << (TW - 1)) @(negedge clk);
        rd(16'h5A40, 32'h1, 32'h1, "R7 flip sets timer status");
        chk("R10 disarmed after event", {31'b0, tmr_armed}, 32'h0);
        // R9: clear on the exact flip cycle
        do @(negedge clk); while (m_tmr[TW-2:0] != {(TW-1){1'b1}});
        io_addr = 16'h5A40; io_wdata = 32'h1; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
        rd(16'h5A40, 32'h1, 32'h1, "R9 timer flip beats clear");
        // R9: power button pulse with clear of bit 8
        @(negedge clk); io_addr = 16'h5A40; io_wdata = 32'h100; io_wr = 1'b1; ev_pwrbtn = 1'b1;
        @(negedge clk); io_wr = 1'b0; ev_pwrbtn = 1'b0;
        rd(16'h5A40, 32'h100, 32'h100, "R9 event beats clear");
        // R11: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(16'h5A42, 32'hFFFF, 32'h0, "R11 enable cleared by reset");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule